// File: doc/BRIEF.md
# Two-Stage Fixed-Format Processor Core

This block is a small 32-bit processor core. It runs a custom instruction set in which every word has the same shape: an 8-bit opcode, an 8-bit destination register field and two 8-bit operand fields. The core reads instructions from a word-addressed instruction memory port with a combinational read. It runs them in two stages. The first stage fetches a word into an instruction register. The second stage decodes and executes that word and writes back its result in one cycle.

The core holds sixteen 32-bit registers. Register 0 always reads as zero, and register 2 starts at 0x000FFFFF as a stack pointer. The arithmetic unit performs add, subtract, multiply and divide, each with a register form and an immediate form. The core also has an absolute jump, two compare-and-skip branches, and a print instruction. The print instruction sends a register value to a display port, together with a one-cycle strobe. A host fills the instruction memory, releases reset and watches the display port.

Top module: `proc_core`

## Requirements
- R1: While reset is held low at a clock edge, the fetch address becomes 0 and the display strobe becomes 0. Register x2 resets to 0x000FFFFF and every other register resets to 0. The fetch address advances by one word on each clock edge after reset is released.
- R2: Bits [31:24] of a word hold the opcode, bits [23:16] the destination, bits [15:8] operand A and bits [7:0] operand B. A register field selects a register by its low four bits, so field 0x13 names x3.
- R3: Register x0 always reads as zero. A write to x0 has no effect.
- R4: The register forms take both sources from operand A and operand B: 0x01 adds, 0x03 subtracts (A minus B), 0x05 multiplies and 0x07 divides. Each result is the low 32 bits of the unsigned operation.
- R5: The immediate forms take the source register from operand A and the zero-extended 8-bit value in operand B: 0x02 adds, 0x04 subtracts, 0x06 multiplies and 0x08 divides.
- R6: A divide by zero, in either form, writes 0xFFFFFFFF to the destination.
- R7: JMP (0x10) loads the program counter with {operand A, operand B}. The word already fetched behind the jump is discarded and never executes.
- R8: BEQ (0x11) skips the next word when the registers named in operand A and operand B are equal. BNEQ (0x12) skips it when they differ. When the condition fails, the next word executes normally.
- R9: PRNT (0x13) presents the register named in operand A on the display data output. The strobe is high for exactly the one cycle after the PRNT executes, so a word at address 0 that runs straight after reset strobes on the second clock edge after release.
- R10: The codes 0x00, 0x09 to 0x0F and 0x14 to 0xFF change no register and produce no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | 16 | Word address of the instruction being fetched |
| imem_data | input | 32 | Instruction word at imem_addr, combinational read |
| disp_data | output | 32 | Value printed by the last PRNT |
| disp_strobe | output | 1 | High for one cycle per PRNT |

## Verification
The arithmetic unit is driven by random programs. Each program first builds two large operands from immediate adds, multiplies and subtracts, then runs one randomly chosen operation in both its register form and its immediate form. This separates a wrong operand order or a sign-extension error from a wrong result. Directed programs cover the cases random stimulus rarely reaches. These are a divide by zero in both forms, a write to x0, destination fields above 15, reserved codes, and a jump that must skip printing words. Both branches are run with the condition true and false. Printing the skipped word tells a skip apart from a fall-through. One strobe is timed exactly against the reset release.

// File: rtl/core_pkg.sv
// Package core_pkg: shared opcodes, widths and reset values of the core.
// Assumes a fixed 32-bit word split into four 8-bit fields.
package core_pkg;
    localparam int INSTR_W = 32;
    localparam int FIELD_W = 8;

    typedef enum logic [FIELD_W-1:0] {
        OP_NOP   = 8'h00,
        OP_ADD   = 8'h01,
        OP_ADDI  = 8'h02,
        OP_SUB   = 8'h03,
        OP_SUBI  = 8'h04,
        OP_MUL   = 8'h05,
        OP_MULI  = 8'h06,
        OP_DIV   = 8'h07,
        OP_DIVI  = 8'h08,
        OP_JMP   = 8'h10,
        OP_BEQ   = 8'h11,
        OP_BNE   = 8'h12,
        OP_PRNT  = 8'h13
    } opcode_e;

    typedef struct packed {
        logic [FIELD_W-1:0] op;
        logic [FIELD_W-1:0] dst;
        logic [FIELD_W-1:0] fa;
        logic [FIELD_W-1:0] fb;
    } instr_t;
endpackage

// File: rtl/core_regfile.sv
// Module core_regfile: register file with two combinational read ports and
// one write port. Entry 0 is forced to zero on read and never stored.
// Assumes one write per cycle; a write appears on reads after the edge.
module core_regfile #(
    parameter int          NREGS    = 16,
    parameter int          DATA_W   = 32,
    parameter int          SP_IDX   = 2,
    parameter logic [31:0] SP_RESET = 32'h000F_FFFF,
    localparam int         IDX_W    = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_a_idx,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [DATA_W-1:0] rd_a_data,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] regs [NREGS];

    // One storage process per register; entry 0 stays constant zero.
    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        if (g == 0) begin : g_zero
            assign regs[g] = '0;
        end else begin : g_store
            always_ff @(posedge clk) begin
                if (!rst_n)
                    regs[g] <= (g == SP_IDX) ? DATA_W'(SP_RESET) : '0;
                else if (wr_en && wr_idx == IDX_W'(g))
                    regs[g] <= wr_data;
            end
        end
    end

    // Read ports: plain array lookup.
    assign rd_a_data = regs[rd_a_idx];
    assign rd_b_data = regs[rd_b_idx];

    // R1: stack pointer holds its reset value in the first cycle after reset.
    a_r1_sp_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> regs[SP_IDX] == DATA_W'(SP_RESET));

    // R3: a write aimed at x0 leaves reads of x0 at zero.
    a_r3_zero_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_idx == '0) |-> rd_a_data == '0);
endmodule

// File: rtl/core_alu.sv
// Module core_alu: single-cycle unsigned arithmetic for register and
// immediate forms. Decides whether the opcode writes back.
// Assumes operand b is already selected (register or zero-extended immediate).
module core_alu
    import core_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [FIELD_W-1:0] op,
    input  logic [DATA_W-1:0]  a,
    input  logic [DATA_W-1:0]  b,
    output logic [DATA_W-1:0]  result,
    output logic               wr_en,
    output logic               imm_form
);
    // Operation select; divide by zero saturates to all ones.
    always_comb begin
        result   = '0;
        wr_en    = 1'b1;
        imm_form = 1'b0;
        unique case (op)
            OP_ADD:  result = a + b;
            OP_ADDI: begin result = a + b; imm_form = 1'b1; end
            OP_SUB:  result = a - b;
            OP_SUBI: begin result = a - b; imm_form = 1'b1; end
            OP_MUL:  result = a * b;
            OP_MULI: begin result = a * b; imm_form = 1'b1; end
            OP_DIV:  result = (b == '0) ? '1 : a / b;
            OP_DIVI: begin result = (b == '0) ? '1 : a / b; imm_form = 1'b1; end
            default: wr_en = 1'b0;
        endcase
    end

    // R4: a sum minus its second operand gives back the first.
    always_comb begin
        if (op == OP_ADD || op == OP_ADDI)
            a_r4_add_inverse: assert (result - b == a);
    end
endmodule

// File: rtl/proc_core.sv
// Module proc_core: two-stage core. Stage one registers the fetched word,
// stage two decodes, executes and writes back in the same cycle.
// Assumes the instruction memory reads combinationally from imem_addr.
module proc_core
    import core_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int          DATA_W   = 32,
    parameter int          NREGS    = 16,
    parameter logic [31:0] SP_RESET = 32'h000F_FFFF,
    localparam int         IDX_W    = $clog2(NREGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    output logic [ADDR_W-1:0]   imem_addr,
    input  logic [INSTR_W-1:0]  imem_data,
    output logic [DATA_W-1:0]   disp_data,
    output logic                disp_strobe
);
    logic [ADDR_W-1:0] pc_q;
    instr_t            ir_q;
    logic [DATA_W-1:0] src_a, src_b, opnd_b, alu_res;
    logic              alu_wr, alu_imm;
    logic              jmp_take, br_take, redirect, is_prnt;
    logic [ADDR_W-1:0] jmp_target;

    // Fetch stage: advance or redirect the PC and capture the word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
            ir_q <= '0;
        end else begin
            pc_q <= jmp_take ? jmp_target : pc_q + 1'b1;
            ir_q <= redirect ? instr_t'('0) : instr_t'(imem_data);
        end
    end

    assign imem_addr = pc_q;

    core_regfile #(
        .NREGS(NREGS), .DATA_W(DATA_W), .SP_IDX(2), .SP_RESET(SP_RESET)
    ) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_a_idx  (ir_q.fa[IDX_W-1:0]),
        .rd_b_idx  (ir_q.fb[IDX_W-1:0]),
        .rd_a_data (src_a),
        .rd_b_data (src_b),
        .wr_en     (alu_wr),
        .wr_idx    (ir_q.dst[IDX_W-1:0]),
        .wr_data   (alu_res)
    );

    // Operand B: register or zero-extended immediate, chosen by opcode form.
    assign opnd_b = alu_imm ? {{(DATA_W-FIELD_W){1'b0}}, ir_q.fb} : src_b;

    core_alu #(.DATA_W(DATA_W)) u_alu (
        .op       (ir_q.op),
        .a        (src_a),
        .b        (opnd_b),
        .result   (alu_res),
        .wr_en    (alu_wr),
        .imm_form (alu_imm)
    );

    // Control decode: jump, skip branches and print.
    always_comb begin
        jmp_target = ADDR_W'({ir_q.fa, ir_q.fb});
        jmp_take   = (ir_q.op == OP_JMP);
        br_take    = ((ir_q.op == OP_BEQ) && (src_a == src_b)) ||
                     ((ir_q.op == OP_BNE) && (src_a != src_b));
        redirect   = jmp_take || br_take;
        is_prnt    = (ir_q.op == OP_PRNT);
    end

    // Display port: register the printed value and a one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            disp_strobe <= 1'b0;
            disp_data   <= '0;
        end else begin
            disp_strobe <= is_prnt;
            if (is_prnt)
                disp_data <= src_a;
        end
    end

    // R1: first cycle after reset fetches address zero.
    a_r1_pc_start: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> pc_q == '0);

    // R7: a jump lands on the target built from operand A and B.
    a_r7_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
        jmp_take |=> pc_q == $past(jmp_target));

    // R7/R8: any redirect replaces the fetched word with a NOP.
    a_r8_flush: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> ir_q == instr_t'('0));

    // R8: a taken skip branch moves the PC on by one more word only.
    a_r8_skip_pc: assert property (@(posedge clk) disable iff (!rst_n)
        br_take |=> pc_q == $past(pc_q) + 1'b1);

    // R9: strobe follows exactly the cycles in which a PRNT executed.
    a_r9_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> disp_strobe == $past(is_prnt));
endmodule

// File: tb/tb_proc_core.sv
module tb_proc_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] imem_addr;
    logic [31:0] imem_data;
    logic [31:0] disp_data;
    logic        disp_strobe;

    logic [31:0] mem [64];
    logic [31:0] prints [64];
    int          pcount;
    int          n_checks = 0;
    int          n_errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    assign imem_data = (imem_addr < 16'd64) ? mem[imem_addr[5:0]] : 32'h0;

    proc_core dut (
        .clk(clk), .rst_n(rst_n), .imem_addr(imem_addr), .imem_data(imem_data),
        .disp_data(disp_data), .disp_strobe(disp_strobe)
    );

    // Capture printed values away from the active edge.
    always @(negedge clk) begin
        if (rst_n && disp_strobe && pcount < 64) begin
            prints[pcount] = disp_data;
            pcount = pcount + 1;
        end
    end

    function automatic logic [31:0] ins(input logic [7:0] op, input logic [7:0] d,
                                        input logic [7:0] a, input logic [7:0] b);
        return {op, d, a, b};
    endfunction

    function automatic logic [31:0] model(input logic [7:0] op, input logic [31:0] a,
                                          input logic [31:0] b);
        case (op)
            8'h01, 8'h02: return a + b;
            8'h03, 8'h04: return a - b;
            8'h05, 8'h06: return a * b;
            8'h07, 8'h08: return (b == 0) ? 32'hFFFF_FFFF : a / b;
            default:      return 32'h0;
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    endtask

    // Reset, then run the loaded program for a number of cycles.
    task automatic run(input int cycles);
        @(negedge clk);
        rst_n = 1'b0;
        pcount = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (cycles) @(negedge clk);
    endtask

    task automatic expect_prints(input string req, input int n, input logic [31:0] e0,
                                 input logic [31:0] e1, input logic [31:0] e2);
        logic [31:0] ex [3];
        ex[0] = e0; ex[1] = e1; ex[2] = e2;
        check(pcount == n, req, 32'(pcount), 32'(n));
        for (int i = 0; i < n && i < 3; i++)
            check(prints[i] == ex[i], req, prints[i], ex[i]);
    endtask

    initial begin
        #(20 * 150000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog: actual=%h expected=%h", 32'h0, 32'h1);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        logic [7:0]  r1, r2, r3, s1, s2, s3, imm, opr;
        logic [31:0] va, vb;
        void'($urandom(32'd24681));
        pcount = 0;
        clear_mem();

        // R1: reset state and strobe timing of a PRNT at address 0.
        mem[0] = ins(8'h13, 8'h00, 8'h02, 8'h00);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(imem_addr == 16'h0, "R1", 32'(imem_addr), 32'h0);
        check(disp_strobe == 1'b0, "R1", 32'(disp_strobe), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(imem_addr == 16'h1, "R1", 32'(imem_addr), 32'h1);
        check(disp_strobe == 1'b0, "R9", 32'(disp_strobe), 32'h0);
        @(negedge clk);
        check(disp_strobe == 1'b1, "R9", 32'(disp_strobe), 32'h1);
        check(disp_data == 32'h000F_FFFF, "R1", disp_data, 32'h000F_FFFF);
        @(negedge clk);
        check(disp_strobe == 1'b0, "R9", 32'(disp_strobe), 32'h0);

        // R1/R3: other registers zero; x0 ignores writes; R2 high field bits.
        clear_mem();
        mem[0] = ins(8'h02, 8'h00, 8'h00, 8'h07);
        mem[1] = ins(8'h13, 8'h00, 8'h00, 8'h00);
        mem[2] = ins(8'h13, 8'h00, 8'h05, 8'h00);
        mem[3] = ins(8'h02, 8'h13, 8'h00, 8'h2A);
        mem[4] = ins(8'h13, 8'h00, 8'hF3, 8'h00);
        mem[5] = ins(8'h10, 8'h00, 8'h00, 8'h05);
        run(20);
        expect_prints("R3_R1_R2", 3, 32'h0, 32'h0, 32'h2A);

        // R6: divide by zero in both forms; example word writes 5 to x1.
        clear_mem();
        mem[0] = 32'h0201_0005;
        mem[1] = ins(8'h07, 8'h04, 8'h01, 8'h00);
        mem[2] = ins(8'h13, 8'h00, 8'h04, 8'h00);
        mem[3] = ins(8'h08, 8'h06, 8'h01, 8'h00);
        mem[4] = ins(8'h13, 8'h00, 8'h06, 8'h00);
        mem[5] = ins(8'h13, 8'h00, 8'h01, 8'h00);
        mem[6] = ins(8'h10, 8'h00, 8'h00, 8'h06);
        run(20);
        expect_prints("R6", 3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h5);

        // R10: reserved codes change nothing and print nothing.
        clear_mem();
        mem[0] = ins(8'h02, 8'h01, 8'h00, 8'h09);
        mem[1] = ins(8'h09, 8'h01, 8'h00, 8'h33);
        mem[2] = ins(8'h0F, 8'h01, 8'h01, 8'h01);
        mem[3] = ins(8'h14, 8'h01, 8'h01, 8'h00);
        mem[4] = ins(8'hFF, 8'h01, 8'h01, 8'h01);
        mem[5] = ins(8'h13, 8'h00, 8'h01, 8'h00);
        mem[6] = ins(8'h10, 8'h00, 8'h00, 8'h06);
        run(20);
        expect_prints("R10", 1, 32'h9, 32'h0, 32'h0);

        // R7: jump skips printing words; the word behind it never runs.
        clear_mem();
        mem[0]  = ins(8'h02, 8'h01, 8'h00, 8'h11);
        mem[1]  = ins(8'h10, 8'h00, 8'h00, 8'h05);
        mem[2]  = ins(8'h13, 8'h00, 8'h02, 8'h00);
        mem[3]  = ins(8'h13, 8'h00, 8'h02, 8'h00);
        mem[5]  = ins(8'h13, 8'h00, 8'h01, 8'h00);
        mem[6]  = ins(8'h10, 8'h00, 8'h00, 8'h06);
        run(20);
        expect_prints("R7", 1, 32'h11, 32'h0, 32'h0);

        // R8: branches taken and not taken.
        clear_mem();
        mem[0]  = ins(8'h02, 8'h01, 8'h00, 8'h03);
        mem[1]  = ins(8'h02, 8'h03, 8'h00, 8'h03);
        mem[2]  = ins(8'h11, 8'h00, 8'h01, 8'h03);
        mem[3]  = ins(8'h13, 8'h00, 8'h02, 8'h00);
        mem[4]  = ins(8'h12, 8'h00, 8'h01, 8'h03);
        mem[5]  = ins(8'h13, 8'h00, 8'h01, 8'h00);
        mem[6]  = ins(8'h12, 8'h00, 8'h01, 8'h00);
        mem[7]  = ins(8'h13, 8'h00, 8'h02, 8'h00);
        mem[8]  = ins(8'h11, 8'h00, 8'h01, 8'h00);
        mem[9]  = ins(8'h13, 8'h00, 8'h03, 8'h00);
        mem[10] = ins(8'h10, 8'h00, 8'h00, 8'h0A);
        run(30);
        expect_prints("R8", 2, 32'h3, 32'h3, 32'h0);

        // R4/R5: random operands through register and immediate forms.
        for (int it = 0; it < 40; it++) begin
            r1 = 8'($urandom); r2 = 8'($urandom); r3 = 8'($urandom);
            s1 = 8'($urandom); s2 = 8'($urandom); s3 = 8'($urandom);
            imm = 8'($urandom);
            opr = 8'(1 + 2 * ($urandom % 4));
            va = model(8'h01, model(8'h05, 32'(r1), 32'(r2)), 32'(r3));
            vb = model(8'h03, model(8'h05, 32'(s1), 32'(s2)), 32'(s3));
            clear_mem();
            mem[0]  = ins(8'h02, 8'h03, 8'h00, r1);
            mem[1]  = ins(8'h06, 8'h03, 8'h03, r2);
            mem[2]  = ins(8'h02, 8'h03, 8'h03, r3);
            mem[3]  = ins(8'h02, 8'h04, 8'h00, s1);
            mem[4]  = ins(8'h06, 8'h04, 8'h04, s2);
            mem[5]  = ins(8'h04, 8'h04, 8'h04, s3);
            mem[6]  = ins(opr, 8'h05, 8'h03, 8'h04);
            mem[7]  = ins(8'h13, 8'h00, 8'h05, 8'h00);
            mem[8]  = ins(opr + 8'h01, 8'h06, 8'h03, imm);
            mem[9]  = ins(8'h13, 8'h00, 8'h06, 8'h00);
            mem[10] = ins(8'h10, 8'h00, 8'h00, 8'h0A);
            run(20);
            check(pcount == 2, "R4_R5", 32'(pcount), 32'h2);
            check(prints[0] == model(opr, va, vb), "R4", prints[0], model(opr, va, vb));
            check(prints[1] == model(opr + 8'h01, va, 32'(imm)), "R5",
                  prints[1], model(opr + 8'h01, va, 32'(imm)));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule